// File: doc/BRIEF.md
# UART transmitter with flow control

This block is the transmit half of an asynchronous serial channel. A host writes characters through a single write strobe. Each character sits in a one-entry holding register until the shift register is idle. The character then moves across, and the holding register is free for the next one, so one full character time of buffering is available. Frame timing comes from a baud tick supplied from outside at sixteen times the bit rate. The frame format is set by configuration inputs: 5 to 8 data bits, parity off, even or odd, one or two stop bits, and a multidrop mode in which an address/data flag takes the place of parity.

Single-cycle command pulses control the transmitter:

- **enable** starts the transmitter.
- **disable** stops it gracefully. Characters already accepted are still sent.
- **reset** stops it at once.
- **break on / break off** hold the line low and then release it.

An optional clear-to-send input gates when a character may start. An optional automatic mode releases the request-to-send output once the transmitter has been disabled and has fully drained.

Top module: `uart_tx_fc`

## Requirements
- R1: After rst_n is released, txd_o and rtsn_o are high, and tx_rdy_o and tx_emt_o are low. The transmitter starts disabled.
- R2: One cycle after a cmd_enable_i pulse, tx_rdy_o and tx_emt_o are high and rtsn_o is low (request asserted).
- R3: A write accepted while tx_rdy_o is high drops tx_rdy_o in the next cycle. If the shifter is idle, the character moves to it one cycle later and tx_rdy_o returns high. A write while tx_rdy_o is low is discarded.
- R4: While the transmitter is disabled, writes are ignored: tx_rdy_o stays low and no frame appears on txd_o.
- R5: A frame is one low start bit, then the data bits least significant first, then the optional extra bit, then one or two high stop bits. Each bit lasts 16 baud ticks. The data bit count is 5 + cfg_len_i (0..3). With cfg_par_en_i set and multidrop off, the extra bit is the XOR of the data bits for even parity (cfg_par_odd_i = 0) and its inverse for odd parity. cfg_stop2_i = 1 selects two stop bits.
- R6: tx_emt_o is high when the transmitter is enabled, the holding register is empty and no frame is in progress. A write clears it.
- R7: After cmd_disable_i, tx_rdy_o drops at once. The frame in progress and any character in the holding register are still sent in full.
- R8: cmd_reset_i aborts any frame and returns txd_o high in the next cycle. It empties the holding register, disables the transmitter and negates rtsn_o. Nothing is sent until a new enable and write.
- R9: cmd_brk_on_i drives txd_o low from the next cycle and holds it low, with no character started. After cmd_brk_off_i, txd_o stays high for at least 16 ticks before any start bit.
- R10: With cfg_cts_en_i set, a frame starts only while ctsn_i is low. A rise of ctsn_i during a frame does not cut that frame short, but no later frame starts until ctsn_i is low again.
- R11: With cfg_rts_auto_i set, rtsn_o goes high 16 ticks after the transmitter is disabled and both registers have finished sending. With it clear, disabling leaves rtsn_o low.
- R12: With cfg_mdrop_i set, the extra bit is always present and equals cfg_addr_i (1 = address, 0 = data), regardless of the parity settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick_i | input | 1 | One-cycle tick at 16x the bit rate |
| wr_stb_i | input | 1 | Holding register write strobe |
| wr_data_i | input | DATA_W | Character to send |
| cmd_enable_i | input | 1 | Enable command pulse |
| cmd_disable_i | input | 1 | Graceful disable command pulse |
| cmd_reset_i | input | 1 | Immediate transmitter reset pulse |
| cmd_brk_on_i | input | 1 | Start break pulse |
| cmd_brk_off_i | input | 1 | Stop break pulse |
| cfg_len_i | input | 2 | Data bits minus 5 |
| cfg_par_en_i | input | 1 | Parity bit present |
| cfg_par_odd_i | input | 1 | Odd parity when 1, even when 0 |
| cfg_stop2_i | input | 1 | Two stop bits when 1 |
| cfg_mdrop_i | input | 1 | Multidrop mode, address/data bit replaces parity |
| cfg_addr_i | input | 1 | Address/data bit value in multidrop mode |
| cfg_cts_en_i | input | 1 | Gate frame starts on ctsn_i |
| cfg_rts_auto_i | input | 1 | Automatic request release after disable |
| ctsn_i | input | 1 | Clear to send, active low |
| txd_o | output | 1 | Serial data out, idle high |
| rtsn_o | output | 1 | Request to send, active low |
| tx_rdy_o | output | 1 | Holding register can take a character |
| tx_emt_o | output | 1 | Transmitter fully empty |

## Verification
The bench builds the block with its default parameters: 8-bit characters and 16 ticks per bit. It supplies a baud tick once every third clock, so bit edges and clock edges are not aligned. With these settings every frame length from 7 to 12 bits can be reached, as can both parity senses and the multidrop flag. Because the full 16-tick windows for break recovery and request release are exercised in real time, their timing can be measured in ticks at the pins.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_EXTRA = 3'd3,
    ST_STOP  = 3'd4,
    ST_BREAK = 3'd5,
    ST_MARK  = 3'd6
  } tx_state_e;

  localparam int unsigned MIN_CHAR_BITS = 5;

endpackage

// File: rtl/uart_tx_rstsync.sv
module uart_tx_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync_o = sync_q[STAGES-1];

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_enable_i,
  input  logic              cmd_disable_i,
  input  logic              cmd_reset_i,
  input  logic              wr_stb_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              load_i,
  output logic              en_o,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);

  logic              en_q, en_nx;
  logic              full_q, full_nx;
  logic [DATA_W-1:0] data_q;
  logic              accept;

  // Writes land only when enabled and the slot is free.
  assign accept = wr_stb_i && en_q && !full_q;

  always_comb begin
    en_nx = en_q;
    if (cmd_reset_i || cmd_disable_i) begin
      en_nx = 1'b0;
    end else if (cmd_enable_i) begin
      en_nx = 1'b1;
    end
  end

  always_comb begin
    full_nx = full_q;
    if (cmd_reset_i) begin
      full_nx = 1'b0;
    end else if (accept) begin
      full_nx = 1'b1;
    end else if (load_i) begin
      full_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      full_q <= 1'b0;
    end else begin
      en_q   <= en_nx;
      full_q <= full_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (accept) begin
      data_q <= wr_data_i;
    end
  end

  assign en_o   = en_q;
  assign full_o = full_q;
  assign data_o = data_q;

  AST_WR_IGNORED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !full_q) |=> !full_q) else $error("write taken while disabled"); // R4

  AST_HELD_UNTIL_MOVED: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !load_i && !cmd_reset_i) |=> full_q) else $error("held character lost"); // R3

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              cmd_reset_i,
  input  logic              brk_on_i,
  input  logic              brk_off_i,
  input  logic              hold_full_i,
  input  logic [DATA_W-1:0] hold_data_i,
  input  logic              cts_ok_i,
  input  logic [1:0]        cfg_len_i,
  input  logic              cfg_par_en_i,
  input  logic              cfg_par_odd_i,
  input  logic              cfg_stop2_i,
  input  logic              cfg_mdrop_i,
  input  logic              cfg_addr_i,
  output logic              load_o,
  output logic              idle_o,
  output logic              txd_o
);

  localparam int unsigned CNT_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);

  tx_state_e         state_q, state_nx;
  logic [CNT_W-1:0]  tcnt_q, tcnt_nx;
  logic [IDX_W-1:0]  bidx_q, bidx_nx;
  logic [DATA_W-1:0] sh_q, sh_nx;
  logic [IDX_W-1:0]  last_q, last_nx;
  logic              hasx_q, hasx_nx;
  logic              xbit_q, xbit_nx;
  logic              stop2_q, stop2_nx;

  logic              bit_end;
  logic              counting;
  logic [IDX_W-1:0]  last_c;
  logic [DATA_W-1:0] mask_c;
  logic              xbit_c;
  logic              load_c;

  assign last_c = IDX_W'(MIN_CHAR_BITS - 1) + IDX_W'(cfg_len_i);

  always_comb begin
    for (int i = 0; i < int'(DATA_W); i++) begin
      mask_c[i] = (i <= int'(last_c));
    end
  end

  assign xbit_c = cfg_mdrop_i ? cfg_addr_i
                              : ((^(hold_data_i & mask_c)) ^ cfg_par_odd_i);

  assign counting = (state_q == ST_START) || (state_q == ST_DATA) ||
                    (state_q == ST_EXTRA) || (state_q == ST_STOP) ||
                    (state_q == ST_MARK);
  assign bit_end  = counting && tick_i && (tcnt_q == CNT_LAST);

  // Next-state logic
  always_comb begin
    state_nx = state_q;
    tcnt_nx  = tcnt_q;
    bidx_nx  = bidx_q;
    sh_nx    = sh_q;
    last_nx  = last_q;
    hasx_nx  = hasx_q;
    xbit_nx  = xbit_q;
    stop2_nx = stop2_q;
    load_c   = 1'b0;

    if (counting && tick_i) begin
      tcnt_nx = bit_end ? '0 : tcnt_q + CNT_W'(1);
    end

    unique case (state_q)
      ST_IDLE: begin
        if (hold_full_i && cts_ok_i) begin
          load_c   = 1'b1;
          state_nx = ST_START;
          tcnt_nx  = '0;
          sh_nx    = hold_data_i;
          last_nx  = last_c;
          hasx_nx  = cfg_mdrop_i || cfg_par_en_i;
          xbit_nx  = xbit_c;
          stop2_nx = cfg_stop2_i;
        end
      end
      ST_START: begin
        if (bit_end) begin
          state_nx = ST_DATA;
          bidx_nx  = '0;
        end
      end
      ST_DATA: begin
        if (bit_end) begin
          sh_nx = sh_q >> 1;
          if (bidx_q == last_q) begin
            state_nx = hasx_q ? ST_EXTRA : ST_STOP;
            bidx_nx  = '0;
          end else begin
            bidx_nx = bidx_q + IDX_W'(1);
          end
        end
      end
      ST_EXTRA: begin
        if (bit_end) begin
          state_nx = ST_STOP;
          bidx_nx  = '0;
        end
      end
      ST_STOP: begin
        if (bit_end) begin
          if (stop2_q && (bidx_q == '0)) begin
            bidx_nx = IDX_W'(1);
          end else begin
            state_nx = ST_IDLE;
          end
        end
      end
      ST_BREAK: begin
        if (brk_off_i) begin
          state_nx = ST_MARK;
          tcnt_nx  = '0;
        end
      end
      ST_MARK: begin
        if (bit_end) begin
          state_nx = ST_IDLE;
        end
      end
      default: state_nx = ST_IDLE;
    endcase

    // Commands override the sequence
    if (cmd_reset_i) begin
      state_nx = ST_IDLE;
      tcnt_nx  = '0;
      load_c   = 1'b0;
    end else if (brk_on_i) begin
      state_nx = ST_BREAK;
      tcnt_nx  = '0;
      load_c   = 1'b0;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      bidx_q  <= '0;
    end else begin
      state_q <= state_nx;
      tcnt_q  <= tcnt_nx;
      bidx_q  <= bidx_nx;
    end
  end

  // Frame registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      last_q  <= '0;
      hasx_q  <= 1'b0;
      xbit_q  <= 1'b0;
      stop2_q <= 1'b0;
    end else begin
      sh_q    <= sh_nx;
      last_q  <= last_nx;
      hasx_q  <= hasx_nx;
      xbit_q  <= xbit_nx;
      stop2_q <= stop2_nx;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: txd_o = 1'b0;
      ST_DATA:  txd_o = sh_q[0];
      ST_EXTRA: txd_o = xbit_q;
      ST_BREAK: txd_o = 1'b0;
      default:  txd_o = 1'b1;
    endcase
  end

  assign load_o = load_c;
  assign idle_o = (state_q == ST_IDLE);

  AST_BIT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && !tick_i && !cmd_reset_i && !brk_on_i) |=> (state_q == ST_START))
    else $error("bit ended without tick"); // R5

  AST_CTS_GATES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !cts_ok_i) |=> (state_q != ST_START))
    else $error("frame started without clear to send"); // R10

  AST_BREAK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BREAK && !cmd_reset_i) |=> (state_q == ST_BREAK || state_q == ST_MARK))
    else $error("break left without guard time"); // R9

  AST_RESET_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset_i |=> (state_q == ST_IDLE && txd_o))
    else $error("reset did not abort frame"); // R8

endmodule

// File: rtl/uart_tx_rts.sv
module uart_tx_rts #(
  parameter int unsigned OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic cmd_enable_i,
  input  logic cmd_reset_i,
  input  logic auto_i,
  input  logic en_i,
  input  logic drained_i,
  output logic rtsn_o
);

  localparam int unsigned CNT_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);

  logic             req_q, req_nx;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             releasing;
  logic             expire;

  assign releasing = auto_i && !en_i && drained_i && req_q;
  assign expire    = releasing && tick_i && (cnt_q == CNT_LAST);

  always_comb begin
    cnt_nx = cnt_q;
    if (!releasing) begin
      cnt_nx = '0;
    end else if (tick_i) begin
      cnt_nx = expire ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_comb begin
    req_nx = req_q;
    if (cmd_reset_i) begin
      req_nx = 1'b0;
    end else if (cmd_enable_i) begin
      req_nx = 1'b1;
    end else if (expire) begin
      req_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      req_q <= req_nx;
      cnt_q <= cnt_nx;
    end
  end

  assign rtsn_o = !req_q;

  AST_RTS_KEPT_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !auto_i && !cmd_reset_i) |=> req_q) else $error("request dropped without auto mode"); // R11

  AST_RTS_KEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !drained_i && !cmd_reset_i) |=> req_q) else $error("request dropped while busy"); // R11

endmodule

// File: rtl/uart_tx_fc.sv
module uart_tx_fc #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick_i,
  input  logic              wr_stb_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              cmd_enable_i,
  input  logic              cmd_disable_i,
  input  logic              cmd_reset_i,
  input  logic              cmd_brk_on_i,
  input  logic              cmd_brk_off_i,
  input  logic [1:0]        cfg_len_i,
  input  logic              cfg_par_en_i,
  input  logic              cfg_par_odd_i,
  input  logic              cfg_stop2_i,
  input  logic              cfg_mdrop_i,
  input  logic              cfg_addr_i,
  input  logic              cfg_cts_en_i,
  input  logic              cfg_rts_auto_i,
  input  logic              ctsn_i,
  output logic              txd_o,
  output logic              rtsn_o,
  output logic              tx_rdy_o,
  output logic              tx_emt_o
);

  logic              rst_n_s;
  logic              en;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              load;
  logic              idle;
  logic              cts_ok;

  uart_tx_rstsync #(.STAGES(2)) u_rst (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_s)
  );

  uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .cmd_enable_i  (cmd_enable_i),
    .cmd_disable_i (cmd_disable_i),
    .cmd_reset_i   (cmd_reset_i),
    .wr_stb_i      (wr_stb_i),
    .wr_data_i     (wr_data_i),
    .load_i        (load),
    .en_o          (en),
    .full_o        (hold_full),
    .data_o        (hold_data)
  );

  assign cts_ok = !cfg_cts_en_i || !ctsn_i;

  uart_tx_shifter #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .tick_i        (baud_tick_i),
    .cmd_reset_i   (cmd_reset_i),
    .brk_on_i      (cmd_brk_on_i),
    .brk_off_i     (cmd_brk_off_i),
    .hold_full_i   (hold_full),
    .hold_data_i   (hold_data),
    .cts_ok_i      (cts_ok),
    .cfg_len_i     (cfg_len_i),
    .cfg_par_en_i  (cfg_par_en_i),
    .cfg_par_odd_i (cfg_par_odd_i),
    .cfg_stop2_i   (cfg_stop2_i),
    .cfg_mdrop_i   (cfg_mdrop_i),
    .cfg_addr_i    (cfg_addr_i),
    .load_o        (load),
    .idle_o        (idle),
    .txd_o         (txd_o)
  );

  uart_tx_rts #(.OVS(OVS)) u_rts (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .tick_i       (baud_tick_i),
    .cmd_enable_i (cmd_enable_i),
    .cmd_reset_i  (cmd_reset_i),
    .auto_i       (cfg_rts_auto_i),
    .en_i         (en),
    .drained_i    (idle && !hold_full),
    .rtsn_o       (rtsn_o)
  );

  assign tx_rdy_o = en && !hold_full;
  assign tx_emt_o = en && !hold_full && idle;

  AST_WRITE_DROPS_RDY: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_stb_i && tx_rdy_o && !cmd_reset_i) |=> !tx_rdy_o) else $error("ready stayed after write"); // R3

  AST_WRITE_CLEARS_EMT: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_stb_i && tx_emt_o) |=> !tx_emt_o) else $error("empty stayed after write"); // R6

endmodule

// File: tb/uart_tx_fc_tb_top.sv
module uart_tx_fc_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 3;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  int         tdiv = 0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic       c_en = 1'b0, c_dis = 1'b0, c_rst = 1'b0, c_bon = 1'b0, c_boff = 1'b0;
  logic [1:0] f_len = 2'd3;
  logic       f_pen = 1'b0, f_podd = 1'b0, f_s2 = 1'b0, f_md = 1'b0, f_adr = 1'b0;
  logic       f_cts = 1'b0, f_rts = 1'b0;
  logic       ctsn = 1'b0;
  logic       txd, rtsn, rdy, emt;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (tdiv == TICK_DIV - 1) begin
      tdiv = 0;
      tick = 1'b1;
    end else begin
      tdiv = tdiv + 1;
      tick = 1'b0;
    end
  end

  uart_tx_fc dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick_i(tick),
    .wr_stb_i(wr_stb), .wr_data_i(wr_data),
    .cmd_enable_i(c_en), .cmd_disable_i(c_dis), .cmd_reset_i(c_rst),
    .cmd_brk_on_i(c_bon), .cmd_brk_off_i(c_boff),
    .cfg_len_i(f_len), .cfg_par_en_i(f_pen), .cfg_par_odd_i(f_podd),
    .cfg_stop2_i(f_s2), .cfg_mdrop_i(f_md), .cfg_addr_i(f_adr),
    .cfg_cts_en_i(f_cts), .cfg_rts_auto_i(f_rts), .ctsn_i(ctsn),
    .txd_o(txd), .rtsn_o(rtsn), .tx_rdy_o(rdy), .tx_emt_o(emt)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_frame(input logic [7:0] d, input int nb, input bit pen,
                                           input bit podd, input bit md, input bit adr,
                                           input bit s2, output int len);
    logic [15:0] f;
    logic [7:0]  m;
    int p;
    f = '1;
    m = 8'((1 << nb) - 1);
    p = 0;
    f[p] = 1'b0; p++;
    for (int i = 0; i < nb; i++) begin f[p] = d[i]; p++; end
    if (md) begin f[p] = adr; p++; end
    else if (pen) begin f[p] = (^(d & m)) ^ podd; p++; end
    f[p] = 1'b1; p++;
    if (s2) begin f[p] = 1'b1; p++; end
    len = p;
    return f;
  endfunction

  task automatic wait_ticks(input int n);
    int k = 0;
    while (k < n) begin
      @(posedge clk);
      if (tick) k++;
    end
    @(negedge clk);
  endtask

  task automatic wait_fall(output bit ok);
    ok = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (txd === 1'b0) begin ok = 1; break; end
    end
  endtask

  task automatic watch_high(input int n, output bit high);
    int k = 0;
    high = 1;
    while (k < n) begin
      @(negedge clk);
      if (txd !== 1'b1) high = 0;
      if (tick) k++;
    end
  endtask

  task automatic rx_check(input logic [15:0] exp, input int len, input bit started, input string req);
    logic [15:0] got;
    logic [15:0] m;
    bit ok;
    got = '1;
    m = 16'((1 << len) - 1);
    if (!started) begin
      wait_fall(ok);
      if (!ok) begin
        chk(0, req, {31'b0, txd}, 32'h0);
        return;
      end
    end
    wait_ticks(8);
    got[0] = txd;
    for (int i = 1; i < len; i++) begin
      wait_ticks(16);
      got[i] = txd;
    end
    chk((got & m) == (exp & m), req, {16'b0, got & m}, {16'b0, exp & m});
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: c_en = 1'b1;
      1: c_dis = 1'b1;
      2: c_rst = 1'b1;
      3: c_bon = 1'b1;
      default: c_boff = 1'b1;
    endcase
    @(negedge clk);
    c_en = 1'b0; c_dis = 1'b0; c_rst = 1'b0; c_bon = 1'b0; c_boff = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_stb = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic set_fmt(input int nb, input bit pen, input bit podd, input bit md,
                         input bit adr, input bit s2);
    f_len = 2'(nb - 5); f_pen = pen; f_podd = podd; f_md = md; f_adr = adr; f_s2 = s2;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] fr;
    int len;
    bit ok, hi;
    int k;
    void'($urandom(32'h5EED_0042));

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk(txd == 1'b1 && rtsn == 1'b1, "R1 lines idle", {30'b0, txd, rtsn}, 32'h3);
    chk(rdy == 1'b0 && emt == 1'b0, "R1 status low", {30'b0, rdy, emt}, 32'h0);

    // R4: write while disabled is ignored
    wr(8'hA5);
    chk(rdy == 1'b0, "R4 ready stays low", {31'b0, rdy}, 32'h0);
    watch_high(40, hi);
    chk(hi, "R4 no frame while disabled", {31'b0, hi}, 32'h1);

    // R2: enable
    pulse(0);
    chk(rdy && emt && !rtsn, "R2 enable status", {29'b0, rdy, emt, rtsn}, 32'h6);

    // R3 / R6: handoff timing and buffering
    set_fmt(8, 0, 0, 0, 0, 0);
    wr(8'h3C);
    chk(!rdy && !emt, "R3 ready drops after write / R6 empty drops", {30'b0, rdy, emt}, 32'h0);
    @(negedge clk);
    chk(rdy, "R3 ready returns after transfer", {31'b0, rdy}, 32'h1);
    wr(8'hC3);
    chk(!rdy, "R3 second write fills holding", {31'b0, rdy}, 32'h0);
    wr(8'hFF);  // discarded, slot occupied
    fr = mk_frame(8'h3C, 8, 0, 0, 0, 0, 0, len);
    rx_check(fr, len, 0, "R3 first frame");
    fr = mk_frame(8'hC3, 8, 0, 0, 0, 0, 0, len);
    rx_check(fr, len, 0, "R3 buffered frame");
    wait_ticks(10);
    chk(emt, "R6 empty after drain", {31'b0, emt}, 32'h1);
    watch_high(40, hi);
    chk(hi, "R3 write while full discarded", {31'b0, hi}, 32'h1);

    // R5 / R12: random formats
    for (int it = 0; it < 18; it++) begin
      int nb;
      bit pen, podd, md, adr, s2;
      logic [7:0] d;
      nb = 5 + int'($urandom_range(0, 3));
      pen = 1'($urandom); podd = 1'($urandom); md = ($urandom_range(0, 3) == 0);
      adr = 1'($urandom); s2 = 1'($urandom);
      d = 8'($urandom);
      set_fmt(nb, pen, podd, md, adr, s2);
      wr(d);
      fr = mk_frame(d, nb, pen, podd, md, adr, s2, len);
      rx_check(fr, len, 0, md ? "R12 random multidrop frame" : "R5 random frame");
      wait_ticks(24);
      chk(emt, "R6 empty between frames", {31'b0, emt}, 32'h1);
    end

    // R12: directed address and data marks, parity settings ignored
    set_fmt(7, 1, 1, 1, 1, 0);
    wr(8'h00);
    fr = mk_frame(8'h00, 7, 1, 1, 1, 1, 0, len);
    rx_check(fr, len, 0, "R12 address mark");
    wait_ticks(12);
    set_fmt(8, 1, 0, 1, 0, 1);
    wr(8'hFF);
    fr = mk_frame(8'hFF, 8, 1, 0, 1, 0, 1, len);
    rx_check(fr, len, 0, "R12 data mark");
    wait_ticks(30);

    // R7 / R11: graceful disable with automatic request release
    set_fmt(8, 0, 0, 0, 0, 0);
    f_rts = 1'b1;
    wr(8'h81);
    wr(8'h7E);
    pulse(1);
    chk(!rdy, "R7 ready low after disable", {31'b0, rdy}, 32'h0);
    fr = mk_frame(8'h81, 8, 0, 0, 0, 0, 0, len);
    rx_check(fr, len, 0, "R7 frame in progress completes");
    fr = mk_frame(8'h7E, 8, 0, 0, 0, 0, 0, len);
    rx_check(fr, len, 0, "R7 held character still sent");
    wait_ticks(20);
    chk(!rtsn, "R11 request held before release", {31'b0, rtsn}, 32'h0);
    wait_ticks(8);
    chk(rtsn, "R11 request released one bit after drain", {31'b0, rtsn}, 32'h1);

    // R11: without auto mode the request stays asserted
    f_rts = 1'b0;
    pulse(0);
    wr(8'h55);
    pulse(1);
    fr = mk_frame(8'h55, 8, 0, 0, 0, 0, 0, len);
    rx_check(fr, len, 0, "R11 frame before manual hold");
    wait_ticks(48);
    chk(!rtsn, "R11 request kept without auto", {31'b0, rtsn}, 32'h0);

    // R8: immediate reset
    pulse(0);
    wr(8'h0F);
    wr(8'hF0);
    wait_fall(ok);
    wait_ticks(20);
    pulse(2);
    chk(txd && !rdy && rtsn, "R8 reset state", {29'b0, txd, rdy, rtsn}, 32'h5);
    watch_high(60, hi);
    chk(hi, "R8 frame aborted and held char dropped", {31'b0, hi}, 32'h1);
    wr(8'h11);
    chk(!rdy, "R8 disabled after reset", {31'b0, rdy}, 32'h0);
    pulse(0);
    chk(emt, "R8 nothing left after re-enable", {31'b0, emt}, 32'h1);
    watch_high(40, hi);
    chk(hi, "R8 no stale frame", {31'b0, hi}, 32'h1);

    // R9: break
    pulse(3);
    chk(!txd, "R9 break drives low", {31'b0, txd}, 32'h0);
    wait_ticks(40);
    chk(!txd, "R9 break held", {31'b0, txd}, 32'h0);
    wr(8'h96);
    wait_ticks(20);
    chk(!txd, "R9 no character during break", {31'b0, txd}, 32'h0);
    pulse(4);
    k = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (txd === 1'b0) break;
      if (tick) k++;
    end
    chk(k >= 16, "R9 guard time after break", k, 16);
    fr = mk_frame(8'h96, 8, 0, 0, 0, 0, 0, len);
    rx_check(fr, len, 1, "R9 frame after break");
    wait_ticks(12);

    // R10: clear-to-send gating
    f_cts = 1'b1;
    ctsn = 1'b1;
    wr(8'h2D);
    watch_high(40, hi);
    chk(hi && !emt, "R10 start held while not clear", {30'b0, hi, emt}, 32'h2);
    ctsn = 1'b0;
    fr = mk_frame(8'h2D, 8, 0, 0, 0, 0, 0, len);
    rx_check(fr, len, 0, "R10 frame after clear");
    wait_ticks(12);
    wr(8'hB4);
    wr(8'h4B);
    wait_fall(ok);
    ctsn = 1'b1;
    fr = mk_frame(8'hB4, 8, 0, 0, 0, 0, 0, len);
    rx_check(fr, len, 1, "R10 frame completes after CTS rise");
    watch_high(40, hi);
    chk(hi && !emt, "R10 next frame waits for CTS", {30'b0, hi, emt}, 32'h2);
    ctsn = 1'b0;
    fr = mk_frame(8'h4B, 8, 0, 0, 0, 0, 0, len);
    rx_check(fr, len, 0, "R10 waiting frame sent");
    f_cts = 1'b0;

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule